// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block sits between a clocked system and an external byte-wide asynchronous static RAM. The system side offers one word at a time through a valid/ready handshake: an address, a write flag, and for writes a data byte. Reads come back as a one-cycle response pulse carrying the captured byte. On the memory side the block produces the active-low chip select, write strobe and output-enable, the address bus, and a split data bus (outgoing byte, incoming byte, and an enable for the pad's tristate driver).

All memory timing is set by nanosecond parameters together with the clock period. Each one is turned into a cycle count by rounding up, and a count of zero becomes one cycle. The sequencer holds every request for the whole memory cycle time. It keeps the address frozen while the chip is selected. It also keeps its own data driver off until the memory's outputs have had time to float after a read.

Top module: `asram_seq`

## Requirements
- R1: During and after reset, with no request, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read (accepted with `req_write`=0) holds `mem_cs_n`=0 and `mem_oe_n`=0 with `mem_we_n`=1 for ACC cycles, ACC = max(ceil(T_AA/CLK), ceil(T_OE/CLK)) (14 at defaults). `mem_dq_i` is captured at the last of those edges. `rsp_valid` is then 1 for exactly one cycle with the captured byte on `rsp_rdata`.
- R3: A write holds `mem_cs_n`=0 with `mem_we_n`=1 for one setup cycle, then `mem_we_n`=0 for PW cycles, PW = max(ceil(T_WP/CLK), ceil(T_DW/CLK), ceil(T_AW/CLK)-1) (9 at defaults). `mem_we_n` and `mem_cs_n` then rise together. `mem_dq_oe` is 1 during the whole strobe and for one hold cycle after it, and `mem_dq_o` and `mem_addr` keep the request's values throughout.
- R4: `mem_addr` equals the accepted request address and does not change while `mem_cs_n` is 0.
- R5: `req_ready` falls in the cycle after acceptance and stays 0 for max(ceil(T_RC/CLK), ceil(T_WC/CLK), phase length) cycles (14 at defaults when no turnaround wait occurs). Requests raised while `req_ready` is 0 are ignored and cause no memory cycle.
- R6: `mem_dq_oe` is never 1 while `mem_cs_n` and `mem_oe_n` are both 0. After a read ends it stays 0 for at least FLT = ceil(T_HZ/CLK) cycles (5 at defaults), delaying a following write if needed.
- R7: `mem_oe_n` and `mem_we_n` are never 0 together. Whenever `mem_cs_n` is 1 both are 1, and between cycles the chip stays deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 8 | Byte read from memory |
| mem_addr | output | 19 | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data pad driver |
| mem_dq_i | input | 8 | Byte received from the memory |

## Verification
Every cycle, the checker watches the control-pin relations: strobe and output-enable exclusivity, deselect implying both idle, the address frozen under chip select, the driver on during the strobe and never against an enabled memory, and the float gap after a read, which it measures with its own counter. It also checks the exact strobe width and the single-cycle response. Only the bench scenarios can show the exact cycle counts: when data is sampled, how long ready stays low, and how many cycles a write is pushed back behind a read. The same holds for the data actually landing in the memory, and for requests made while busy being dropped.

// File: rtl/asram_seq_pkg.sv
package asram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD     = 3'd1,
    ST_WSET   = 3'd2,
    ST_WPUL   = 3'd3,
    ST_WHOLD  = 3'd4,
    ST_SETTLE = 3'd5
  } seq_state_t;

  // Nanosecond minimum to cycle count: round up, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Strobe width: covers pulse width, data setup and address setup
  // (address setup also gets the one setup cycle ahead of the strobe).
  function automatic int unsigned strobe_cyc(input int unsigned wp, input int unsigned dw,
                                             input int unsigned aw);
    int unsigned a;
    a = (aw > 1) ? aw - 1 : 1;
    return umax(umax(wp, dw), a);
  endfunction

endpackage

// File: rtl/asram_seq_timer.sv
module asram_seq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign count = cnt_q;
  assign zero  = (cnt_q == '0);

endmodule

// File: rtl/asram_seq_fsm.sv
module asram_seq_fsm
  import asram_seq_pkg::*;
#(
  parameter int ACC_C = 14,
  parameter int PW_C  = 9,
  parameter int CYC_C = 14,
  parameter int FLT_C = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic mem_cs_n,
  output logic mem_we_n,
  output logic mem_oe_n,
  output logic mem_dq_oe,
  output logic ev_sample,
  output logic ev_wr_commit
);

  localparam int AGE_MAX = CYC_C + ACC_C + PW_C + FLT_C + 4;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);
  localparam int PH_W    = $clog2(PW_C + 1);
  localparam int FLT_W   = $clog2(FLT_C + 1);

  seq_state_t       state_q, state_d;
  logic [AGE_W-1:0] age_q;
  logic             ph_load, ph_zero, flt_zero, cycle_met;
  logic [PH_W-1:0]  ph_count;
  logic [FLT_W-1:0] flt_count;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign cycle_met = (age_q >= AGE_W'(CYC_C));

  // Read capture edge: the access count has run out.
  assign ev_sample    = (state_q == ST_RD) && (age_q == AGE_W'(ACC_C));
  assign ph_load      = (state_q == ST_WSET) && flt_zero;
  assign ev_wr_commit = (state_q == ST_WPUL) && ph_zero;

  asram_seq_timer #(.W(PH_W)) u_ph (
    .clk(clk), .rst_n(rst_n), .load(ph_load),
    .load_val(PH_W'(PW_C - 1)), .count(ph_count), .zero(ph_zero)
  );

  // Output-float guard, started when a read releases the bus.
  asram_seq_timer #(.W(FLT_W)) u_flt (
    .clk(clk), .rst_n(rst_n), .load(ev_sample),
    .load_val(FLT_W'(FLT_C)), .count(flt_count), .zero(flt_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                                   age_q <= '0;
    else if (accept)                              age_q <= AGE_W'(1);
    else if (state_q != ST_IDLE && age_q != AGE_W'(AGE_MAX)) age_q <= age_q + 1'b1;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = req_write ? ST_WSET : ST_RD;
      ST_RD:     if (ev_sample) state_d = cycle_met ? ST_IDLE : ST_SETTLE;
      ST_WSET:   if (flt_zero) state_d = ST_WPUL;
      ST_WPUL:   if (ph_zero) state_d = ST_WHOLD;
      ST_WHOLD:  state_d = cycle_met ? ST_IDLE : ST_SETTLE;
      ST_SETTLE: if (cycle_met) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    mem_cs_n  = !((state_q == ST_RD) || (state_q == ST_WSET) || (state_q == ST_WPUL));
    mem_we_n  = (state_q != ST_WPUL);
    mem_oe_n  = (state_q != ST_RD);
    mem_dq_oe = ((state_q == ST_WSET) && flt_zero) || (state_q == ST_WPUL)
              || (state_q == ST_WHOLD);
  end

  logic unused_ok;
  assign unused_ok = ^{ph_count, flt_count};

endmodule

// File: rtl/asram_seq_dpath.sv
module asram_seq_dpath #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          ev_sample,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_dq_o <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= ev_sample;
      if (ev_sample) rsp_rdata <= mem_dq_i;
    end
  end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_seq_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 4,
  parameter int T_RC_NS = 55,
  parameter int T_WC_NS = 55,
  parameter int T_AA_NS = 55,
  parameter int T_OE_NS = 25,
  parameter int T_WP_NS = 35,
  parameter int T_DW_NS = 25,
  parameter int T_AW_NS = 40,
  parameter int T_HZ_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int ACC_C = umax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int PW_C  = strobe_cyc(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS),
                                    ns_to_cyc(T_AW_NS, CLK_NS));
  localparam int CYC_C = umax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_WC_NS, CLK_NS));
  localparam int FLT_C = ns_to_cyc(T_HZ_NS, CLK_NS);

  logic accept, ev_sample, ev_wr_commit;

  asram_seq_fsm #(.ACC_C(ACC_C), .PW_C(PW_C), .CYC_C(CYC_C), .FLT_C(FLT_C)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .accept(accept),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe),
    .ev_sample(ev_sample), .ev_wr_commit(ev_wr_commit)
  );

  asram_seq_dpath #(.AW(ADDR_W), .DW(DATA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr), .req_wdata(req_wdata),
    .ev_sample(ev_sample), .mem_dq_i(mem_dq_i), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/asram_seq_chk.sv
module asram_seq_chk #(
  parameter int ADDR_W = 19,
  parameter int PW_C   = 9,
  parameter int FLT_C  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic              ev_wr_commit
);

  localparam int WL_W = $clog2(PW_C + 2);
  localparam int HZ_W = $clog2(FLT_C + 2);

  logic [WL_W-1:0] we_low_cnt;
  logic [HZ_W-1:0] since_rd;

  always_ff @(posedge clk) begin
    if (!rst_n)         we_low_cnt <= '0;
    else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1'b1;
    else                we_low_cnt <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        since_rd <= HZ_W'(FLT_C);
    else if (!mem_cs_n && !mem_oe_n)   since_rd <= '0;
    else if (since_rd < HZ_W'(FLT_C))  since_rd <= since_rd + 1'b1;
  end

  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R2
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n));
  // R3
  strobe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);
  // R3
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && $past(!mem_we_n)) |-> (we_low_cnt == WL_W'(PW_C)));
  // R3
  commit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_commit |=> (mem_we_n && mem_cs_n && mem_dq_oe));
  // R4
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  // R5
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);
  // R6
  no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !(!mem_cs_n && !mem_oe_n));
  // R6
  float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (since_rd >= HZ_W'(FLT_C)));
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  // R7
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_oe_n && mem_we_n));

endmodule

bind asram_seq asram_seq_chk #(.ADDR_W(ADDR_W), .PW_C(PW_C), .FLT_C(FLT_C)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_oe(mem_dq_oe), .ev_wr_commit(ev_wr_commit)
);

// File: tb/sim_asram_seq.sv
`timescale 1ns/1ps
module sim_asram_seq;

  localparam int CLK = 4;
  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int ACC  = (cyc(55) > cyc(25)) ? cyc(55) : cyc(25);
  localparam int PWX  = (cyc(35) > cyc(25)) ? cyc(35) : cyc(25);
  localparam int PW   = (PWX > cyc(40) - 1) ? PWX : cyc(40) - 1;
  localparam int BUSY = cyc(55);
  localparam int FLT  = cyc(20);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [18:0] mem_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK/2) clk = ~clk;

  asram_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Memory model: 256 bytes on the low address bits.
  logic [7:0] mem [256];
  int   rd_cnt = 0;
  bit   wr_prev = 0;
  logic [7:0] wr_data_prev;
  logic [7:0] wr_addr_prev;
  always @(posedge clk) begin
    if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_cnt <= rd_cnt + 1; else rd_cnt <= 0;
    if (wr_prev && (mem_we_n || mem_cs_n)) mem[wr_addr_prev] <= wr_data_prev;
    wr_prev      <= !mem_cs_n && !mem_we_n;
    wr_data_prev <= mem_dq_oe ? mem_dq_o : 8'hxx;
    wr_addr_prev <= mem_addr[7:0];
  end
  assign mem_dq_i = (!mem_cs_n && !mem_oe_n && mem_we_n && rd_cnt >= ACC - 1)
                    ? mem[mem_addr[7:0]] : 8'hEE;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R6 contention monitor
  int since = 99;
  int mon_err = 0;
  always @(negedge clk) begin
    if (!mem_cs_n && !mem_oe_n) since = 0; else if (since < 99) since++;
    if (rst_n && mem_dq_oe && since <= FLT) begin
      mon_err++;
      $display("FAIL R6: driver on %0d cycles after read, expected > %0d", since, FLT);
    end
  end

  task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  // Runs one operation and observes 20 cycles from acceptance.
  task automatic run_op(input bit wr, input logic [18:0] a, input logic [7:0] d,
                        output int we_first, output int we_len, output int oe_len,
                        output int rdy_low, output int rsp_cyc, output logic [7:0] rsp_d,
                        output bit addr_ok, output bit drv_ok, output bit hold_ok);
    we_first = -1; we_len = 0; oe_len = 0; rdy_low = 0; rsp_cyc = -1; rsp_d = 'x;
    addr_ok = 1; drv_ok = 1; hold_ok = !wr;
    issue(wr, a, d);
    for (int k = 1; k <= 20; k++) begin
      if (!mem_we_n) begin
        if (we_first < 0) we_first = k;
        we_len++;
        if (!mem_dq_oe || mem_dq_o !== d) drv_ok = 0;
      end
      if (!mem_oe_n) oe_len++;
      if (!req_ready && rdy_low == k - 1) rdy_low++;
      if (rsp_valid) begin rsp_cyc = k; rsp_d = rsp_rdata; end
      if (!mem_cs_n && mem_addr !== a) addr_ok = 0;
      if (wr && k == PW + 2)
        hold_ok = mem_cs_n && mem_we_n && mem_dq_oe && mem_addr === a && mem_dq_o === d;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_we_n && mem_oe_n, "R1 controls idle in reset", {mem_cs_n, mem_we_n, mem_oe_n}, 7);
    rst_n = 1;
    @(negedge clk);
    check(!mem_dq_oe && req_ready && !rsp_valid, "R1 driver/ready/rsp after reset",
          {mem_dq_oe, req_ready, rsp_valid}, 2);
    check(mem_cs_n && mem_we_n && mem_oe_n, "R1 controls idle after reset", {mem_cs_n, mem_we_n, mem_oe_n}, 7);
  endtask

  task automatic t_write(input logic [18:0] a, input logic [7:0] d);
    int wf, wl, ol, rl, rc; logic [7:0] rd; bit ao, dok, hok;
    run_op(1, a, d, wf, wl, ol, rl, rc, rd, ao, dok, hok);
    check(wf == 2, "R3 strobe starts after setup cycle", wf, 2);
    check(wl == PW, "R3 strobe width", wl, PW);
    check(dok, "R3 data driven during strobe", dok, 1);
    check(hok, "R3 hold cycle after strobe", hok, 1);
    check(ol == 0, "R7 no output enable in write", ol, 0);
    check(ao, "R4 address under chip select", ao, 1);
    check(rl == BUSY, "R5 ready low for write cycle", rl, BUSY);
  endtask

  task automatic t_read(input logic [18:0] a, input logic [7:0] exp);
    int wf, wl, ol, rl, rc; logic [7:0] rd; bit ao, dok, hok;
    run_op(0, a, 8'h00, wf, wl, ol, rl, rc, rd, ao, dok, hok);
    check(ol == ACC && wl == 0, "R2 access window", ol, ACC);
    check(rc == ACC + 1, "R2 response cycle", rc, ACC + 1);
    check(rd === exp, "R2 read data", rd, exp);
    check(ao, "R4 address under chip select (read)", ao, 1);
    check(rl == BUSY, "R5 ready low for read cycle", rl, BUSY);
  endtask

  task automatic t_rsp_pulse();
    int n = 0;
    issue(0, 19'h0_0011, 8'h00);
    for (int k = 0; k < 20; k++) begin
      if (rsp_valid) n++;
      @(negedge clk);
    end
    check(n == 1, "R2 single response pulse", n, 1);
  endtask

  task automatic t_turnaround();
    int gap = 0;
    issue(0, 19'h1_0042, 8'h00);
    while (!rsp_valid) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 19'h2_0043; req_wdata = 8'h5A;
    while (!mem_dq_oe && gap < 40) begin
      gap++;
      @(negedge clk);
      req_valid = 0;
    end
    check(gap >= FLT && gap < 40, "R6 driver held off after read", gap, FLT);
    while (!req_ready) @(negedge clk);
    t_read(19'h2_0043, 8'h5A);
  endtask

  task automatic t_ignore_busy();
    bit stray = 0, cs_idle = 1;
    issue(1, 19'h0_0070, 8'h71);
    for (int k = 0; k < 6; k++) begin
      req_valid = 1; req_write = 1; req_addr = 19'h0_0090; req_wdata = 8'hFF;
      @(negedge clk);
    end
    req_valid = 0;
    while (!req_ready) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      if (!mem_cs_n) cs_idle = 0;
      if (!mem_we_n) stray = 1;
      @(negedge clk);
    end
    check(cs_idle && !stray, "R7 deselected between cycles", cs_idle, 1);
    t_read(19'h0_0090, 8'h99);
    t_read(19'h0_0070, 8'h71);
  endtask

  initial begin
    #(CLK * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h09);
    @(negedge clk);
    t_reset();
    t_write(19'h5_A3C3, 8'h3C);
    t_read(19'h5_A3C3, 8'h3C);
    t_write(19'h7_FF00, 8'h00);
    t_write(19'h0_0001, 8'hFF);
    t_read(19'h7_FF00, 8'h00);
    t_read(19'h0_0001, 8'hFF);
    t_read(19'h3_0055, 8'h5C);
    t_rsp_pulse();
    t_turnaround();
    t_ignore_busy();
    check(mon_err == 0, "R6 no contention seen", mon_err, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule